// File: doc/BRIEF.md
# Shared SRAM Port Arbiter with Typed Priority and Starvation Relief

This block sits in front of a single-port SRAM and decides, every cycle, which of three request classes may use the memory. Two classes come from a cache-coherent processor-side port, one carrying reads and one carrying writes. The third class comes from an interconnect-side port that merges several bus masters and carries both reads and writes. Each class has its own valid/ready handshake. A request stays asserted until its ready is seen. The grant is combinational from the current requests, so a winning request is accepted in the cycle it is presented.

The priority order depends on the transaction type. Processor reads always rank first. By default, processor writes rank second and interconnect traffic ranks third. A configuration input moves processor writes to the bottom of the order, below the interconnect port. Processor reads stay on top either way. The configuration is captured in a register, so a change steers arbitration only from the following cycle onward.

A per-class wait counter guarantees progress. A request that has gone ungranted for a set number of consecutive cycles is granted next, ahead of normal priority. The granted command is steered onto the memory port. For granted reads, a one-cycle-later response strobe is returned on the port that issued the read, together with the memory's read data.

Top module: `sram_port_arb`

## Requirements
- R1: At most one of `prd_ready`, `pwr_ready`, `ic_ready` is high in any cycle, and a ready is high only while its valid is high.
- R2: With the demote bit clear and no class starving, the order is processor read, then processor write, then interconnect.
- R3: Unless another class is starving, a valid processor read is always granted, whatever the state of the demote bit.
- R4: With the demote bit set and no class starving, the order is processor read, then interconnect, then processor write.
- R5: `cfg_wr_demote` is registered. A change applied in one cycle governs arbitration from the next cycle on, and the cycle in which it changes still uses the old value.
- R6: A class whose request has gone ungranted for STARVE_LIMIT consecutive cycles is starving. Starving classes take precedence over all others. Among several starving classes, the order of R2 or R4 applies. Granting a class returns it to normal priority.
- R7: A class's wait count restarts from zero when its valid drops or when it is granted.
- R8: When a grant is issued, `mem_en` is 1, and `mem_addr` comes from the granted port. `mem_we` is 0 for a processor read, 1 for a processor write, and `ic_we` for the interconnect. On writes, `mem_wdata` comes from the granted port. With no grant, `mem_en` is 0.
- R9: A granted read raises `prd_rvalid` or `ic_rvalid` (matching the issuing port) in exactly the next cycle, with `prd_rdata`/`ic_rdata` equal to `mem_rdata`. No other cycle raises them.
- R10: While `rst_n` is low, both response strobes are low, the wait counts are zero, and the demote bit reads as clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_demote | input | 1 | 1 ranks processor writes below interconnect traffic |
| prd_valid | input | 1 | Processor read request |
| prd_ready | output | 1 | Processor read granted |
| prd_addr | input | ADDR_W | Processor read word address |
| prd_rvalid | output | 1 | Processor read data valid |
| prd_rdata | output | DATA_W | Processor read data |
| pwr_valid | input | 1 | Processor write request |
| pwr_ready | output | 1 | Processor write granted |
| pwr_addr | input | ADDR_W | Processor write word address |
| pwr_wdata | input | DATA_W | Processor write data |
| ic_valid | input | 1 | Interconnect request |
| ic_ready | output | 1 | Interconnect request granted |
| ic_we | input | 1 | Interconnect request is a write |
| ic_addr | input | ADDR_W | Interconnect word address |
| ic_wdata | input | DATA_W | Interconnect write data |
| ic_rvalid | output | 1 | Interconnect read data valid |
| ic_rdata | output | DATA_W | Interconnect read data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read strobe |

## Verification
The bench builds the arbiter with STARVE_LIMIT at 5, DATA_W at 32 and ADDR_W at 8. The short limit lets a continuously busy processor read stream push the lower classes into starvation within a few cycles. It also lets two or three classes starve at once, which exercises the priority order applied among starving requests. The 256-word address space is small enough that writes and later reads often hit the same words, so read data checks exercise real round trips through a memory modelled in the bench. Phases with the demote bit fixed low, fixed high and toggling every few cycles cover both orders and the one-cycle lag after each change.

// File: rtl/sarb_pkg.sv
package sarb_pkg;
  localparam int unsigned N_CLS = 3;
  localparam logic [1:0] CLS_PRD = 2'd0;
  localparam logic [1:0] CLS_PWR = 2'd1;
  localparam logic [1:0] CLS_IC  = 2'd2;
endpackage

// File: rtl/sarb_wait_ctr.sv
module sarb_wait_ctr #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic gnt_i,
  output logic starve_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    if (!req_i || gnt_i)      cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
    cnt_en = req_i || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign starve_o = req_i && (cnt_q == CNT_MAX);
endmodule

// File: rtl/sarb_pick.sv
module sarb_pick
  import sarb_pkg::*;
(
  input  logic [N_CLS-1:0] req_i,
  input  logic [N_CLS-1:0] starve_i,
  input  logic             demote_i,
  output logic [N_CLS-1:0] gnt_o
);
  logic [N_CLS-1:0] cand;
  logic [1:0]       ord [N_CLS];
  logic             found;

  always_comb begin
    cand   = (|starve_i) ? starve_i : req_i;
    ord[0] = CLS_PRD;
    ord[1] = demote_i ? CLS_IC  : CLS_PWR;
    ord[2] = demote_i ? CLS_PWR : CLS_IC;
    gnt_o  = '0;
    found  = 1'b0;
    for (int i = 0; i < int'(N_CLS); i++) begin
      if (!found && cand[ord[i]]) begin
        gnt_o[ord[i]] = 1'b1;
        found         = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sarb_route.sv
module sarb_route
  import sarb_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CLS-1:0]  gnt_i,
  input  logic [ADDR_W-1:0] prd_addr_i,
  input  logic [ADDR_W-1:0] pwr_addr_i,
  input  logic [DATA_W-1:0] pwr_wdata_i,
  input  logic              ic_we_i,
  input  logic [ADDR_W-1:0] ic_addr_i,
  input  logic [DATA_W-1:0] ic_wdata_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              prd_rvalid_o,
  output logic              ic_rvalid_o
);
  logic [1:0] rsp_q, rsp_d;
  logic       rsp_en;

  always_comb begin
    mem_en_o    = |gnt_i;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (gnt_i[CLS_PRD]) begin
      mem_addr_o = prd_addr_i;
    end else if (gnt_i[CLS_PWR]) begin
      mem_we_o    = 1'b1;
      mem_addr_o  = pwr_addr_i;
      mem_wdata_o = pwr_wdata_i;
    end else if (gnt_i[CLS_IC]) begin
      mem_we_o    = ic_we_i;
      mem_addr_o  = ic_addr_i;
      mem_wdata_o = ic_wdata_i;
    end
  end

  always_comb begin
    rsp_d  = {gnt_i[CLS_IC] & ~ic_we_i, gnt_i[CLS_PRD]};
    rsp_en = (|rsp_q) | (|rsp_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_q <= '0;
    else if (rsp_en) rsp_q <= rsp_d;
  end

  assign prd_rvalid_o = rsp_q[0];
  assign ic_rvalid_o  = rsp_q[1];
endmodule

// File: rtl/sram_port_arb.sv
module sram_port_arb
  import sarb_pkg::*;
#(
  parameter int unsigned ADDR_W       = 14,
  parameter int unsigned DATA_W       = 128,
  parameter int unsigned STARVE_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_demote,
  input  logic              prd_valid,
  output logic              prd_ready,
  input  logic [ADDR_W-1:0] prd_addr,
  output logic              prd_rvalid,
  output logic [DATA_W-1:0] prd_rdata,
  input  logic              pwr_valid,
  output logic              pwr_ready,
  input  logic [ADDR_W-1:0] pwr_addr,
  input  logic [DATA_W-1:0] pwr_wdata,
  input  logic              ic_valid,
  output logic              ic_ready,
  input  logic              ic_we,
  input  logic [ADDR_W-1:0] ic_addr,
  input  logic [DATA_W-1:0] ic_wdata,
  output logic              ic_rvalid,
  output logic [DATA_W-1:0] ic_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [N_CLS-1:0] req, gnt, starve;
  logic             demote_q, demote_en;

  assign req = {ic_valid, pwr_valid, prd_valid};

  // configuration bit: captured so a change steers the following cycle
  assign demote_en = cfg_wr_demote ^ demote_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         demote_q <= 1'b0;
    else if (demote_en) demote_q <= cfg_wr_demote;
  end

  for (genvar c = 0; c < int'(N_CLS); c++) begin : g_wait
    sarb_wait_ctr #(.LIMIT(STARVE_LIMIT)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req[c]),
      .gnt_i    (gnt[c]),
      .starve_o (starve[c])
    );
  end

  sarb_pick u_pick (
    .req_i    (req),
    .starve_i (starve),
    .demote_i (demote_q),
    .gnt_o    (gnt)
  );

  sarb_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .clk          (clk),
    .rst_n        (rst_n),
    .gnt_i        (gnt),
    .prd_addr_i   (prd_addr),
    .pwr_addr_i   (pwr_addr),
    .pwr_wdata_i  (pwr_wdata),
    .ic_we_i      (ic_we),
    .ic_addr_i    (ic_addr),
    .ic_wdata_i   (ic_wdata),
    .mem_en_o     (mem_en),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .prd_rvalid_o (prd_rvalid),
    .ic_rvalid_o  (ic_rvalid)
  );

  assign prd_ready = gnt[CLS_PRD];
  assign pwr_ready = gnt[CLS_PWR];
  assign ic_ready  = gnt[CLS_IC];
  assign prd_rdata = mem_rdata;
  assign ic_rdata  = mem_rdata;
endmodule

// File: rtl/sram_port_arb_chk.sv
module sram_port_arb_chk #(
  parameter int unsigned ADDR_W       = 14,
  parameter int unsigned DATA_W       = 128,
  parameter int unsigned STARVE_LIMIT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prd_valid,
  input logic              prd_ready,
  input logic [ADDR_W-1:0] prd_addr,
  input logic              prd_rvalid,
  input logic              pwr_valid,
  input logic              pwr_ready,
  input logic [ADDR_W-1:0] pwr_addr,
  input logic [DATA_W-1:0] pwr_wdata,
  input logic              ic_valid,
  input logic              ic_ready,
  input logic              ic_we,
  input logic [ADDR_W-1:0] ic_addr,
  input logic              ic_rvalid,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  localparam int unsigned BOUND = STARVE_LIMIT + 2;

  int unsigned prd_wait_q, pwr_wait_q, ic_wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_wait_q <= 0;
      pwr_wait_q <= 0;
      ic_wait_q  <= 0;
    end else begin
      prd_wait_q <= (prd_valid && !prd_ready) ? prd_wait_q + 1 : 0;
      pwr_wait_q <= (pwr_valid && !pwr_ready) ? pwr_wait_q + 1 : 0;
      ic_wait_q  <= (ic_valid  && !ic_ready)  ? ic_wait_q  + 1 : 0;
    end
  end

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prd_ready, pwr_ready, ic_ready}));

  // R1
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_ready -> prd_valid) && (pwr_ready -> pwr_valid) && (ic_ready -> ic_valid));

  // R6
  bounded_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_wait_q <= BOUND) && (pwr_wait_q <= BOUND) && (ic_wait_q <= BOUND));

  // R8
  prd_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prd_ready |-> (mem_en && !mem_we && mem_addr == prd_addr));

  // R8
  pwr_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ready |-> (mem_en && mem_we && mem_addr == pwr_addr && mem_wdata == pwr_wdata));

  // R8
  ic_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ic_ready |-> (mem_en && mem_we == ic_we && mem_addr == ic_addr));

  // R8
  idle_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prd_ready || pwr_ready || ic_ready) |-> !mem_en);

  // R9
  prd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prd_ready |=> prd_rvalid);

  // R9
  ic_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_ready && !ic_we) |=> ic_rvalid);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!prd_rvalid && !ic_rvalid));
endmodule

bind sram_port_arb sram_port_arb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STARVE_LIMIT(STARVE_LIMIT)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .prd_valid(prd_valid), .prd_ready(prd_ready), .prd_addr(prd_addr), .prd_rvalid(prd_rvalid),
  .pwr_valid(pwr_valid), .pwr_ready(pwr_ready), .pwr_addr(pwr_addr), .pwr_wdata(pwr_wdata),
  .ic_valid(ic_valid), .ic_ready(ic_ready), .ic_we(ic_we), .ic_addr(ic_addr), .ic_rvalid(ic_rvalid),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/sram_port_arb_tb_top.sv
`timescale 1ns/1ps
module sram_port_arb_tb_top;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int LIM = 5;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr_demote;
  logic prd_valid, prd_ready, prd_rvalid;
  logic [AW-1:0] prd_addr;
  logic [DW-1:0] prd_rdata;
  logic pwr_valid, pwr_ready;
  logic [AW-1:0] pwr_addr;
  logic [DW-1:0] pwr_wdata;
  logic ic_valid, ic_ready, ic_we, ic_rvalid;
  logic [AW-1:0] ic_addr;
  logic [DW-1:0] ic_wdata, ic_rdata;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  sram_port_arb #(.ADDR_W(AW), .DATA_W(DW), .STARVE_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_demote(cfg_wr_demote),
    .prd_valid(prd_valid), .prd_ready(prd_ready), .prd_addr(prd_addr),
    .prd_rvalid(prd_rvalid), .prd_rdata(prd_rdata),
    .pwr_valid(pwr_valid), .pwr_ready(pwr_ready), .pwr_addr(pwr_addr), .pwr_wdata(pwr_wdata),
    .ic_valid(ic_valid), .ic_ready(ic_ready), .ic_we(ic_we), .ic_addr(ic_addr),
    .ic_wdata(ic_wdata), .ic_rvalid(ic_rvalid), .ic_rdata(ic_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // memory behind the arbiter
  logic [DW-1:0] mem_b [256];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem_b[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem_b[mem_addr];
    end
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mon_on = 0, r7_phase = 0, done = 0;

  // reference model state
  int            wcnt [3];
  bit            dem_m;
  int            rsp_kind;
  logic [DW-1:0] rsp_data;
  logic [DW-1:0] mem_m [256];
  bit            got [3];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      check(0, "R1", "watchdog", cyc, WATCHDOG);
      finish_run();
    end
  end

  // cycle-by-cycle reference, evaluated mid-cycle
  always @(negedge clk) begin
    bit v [3];
    bit st [3];
    bit cand [3];
    bit g [3];
    bit anyst;
    int ord [3];
    int win;
    string tag;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin wcnt[i] = 0; got[i] = 0; end
      dem_m = 0; rsp_kind = 0;
    end else if (mon_on) begin
      v[0] = prd_valid; v[1] = pwr_valid; v[2] = ic_valid;
      anyst = 0;
      for (int i = 0; i < 3; i++) begin st[i] = v[i] && wcnt[i] == LIM; anyst |= st[i]; end
      for (int i = 0; i < 3; i++) cand[i] = anyst ? st[i] : v[i];
      ord[0] = 0; ord[1] = dem_m ? 2 : 1; ord[2] = dem_m ? 1 : 2;
      win = -1;
      for (int i = 0; i < 3; i++) if (win < 0 && cand[ord[i]]) win = ord[i];
      for (int i = 0; i < 3; i++) g[i] = (win == i);
      if (r7_phase)                 tag = "R7";
      else if (anyst)               tag = "R6";
      else if (cfg_wr_demote != dem_m) tag = "R5";
      else if (v[0])                tag = "R3";
      else if (dem_m)               tag = "R4";
      else                          tag = "R2";
      check({ic_ready, pwr_ready, prd_ready} == {g[2], g[1], g[0]}, tag, "grant",
            {ic_ready, pwr_ready, prd_ready}, {g[2], g[1], g[0]});
      check(!((prd_ready && !prd_valid) || (pwr_ready && !pwr_valid) || (ic_ready && !ic_valid))
            && $countones({ic_ready, pwr_ready, prd_ready}) <= 1, "R1", "ready set",
            {ic_ready, pwr_ready, prd_ready}, {ic_valid, pwr_valid, prd_valid});
      // routing
      if (win == 0)
        check(mem_en && !mem_we && mem_addr == prd_addr, "R8", "prd route",
              {mem_en, mem_we, mem_addr}, {1'b1, 1'b0, prd_addr});
      else if (win == 1)
        check(mem_en && mem_we && mem_addr == pwr_addr && mem_wdata == pwr_wdata, "R8",
              "pwr route", {mem_en, mem_we, mem_addr, mem_wdata}, {1'b1, 1'b1, pwr_addr, pwr_wdata});
      else if (win == 2)
        check(mem_en && mem_we == ic_we && mem_addr == ic_addr && (!ic_we || mem_wdata == ic_wdata),
              "R8", "ic route", {mem_en, mem_we, mem_addr}, {1'b1, ic_we, ic_addr});
      else
        check(!mem_en, "R8", "idle mem", mem_en, 0);
      // responses
      check(prd_rvalid == (rsp_kind == 1) && ic_rvalid == (rsp_kind == 2), "R9", "rvalid",
            {ic_rvalid, prd_rvalid}, {rsp_kind == 2, rsp_kind == 1});
      if (rsp_kind == 1) check(prd_rdata == rsp_data, "R9", "prd rdata", prd_rdata, rsp_data);
      if (rsp_kind == 2) check(ic_rdata == rsp_data, "R9", "ic rdata", ic_rdata, rsp_data);
      // advance model to next cycle
      rsp_kind = 0;
      if (win == 0) begin rsp_kind = 1; rsp_data = mem_m[prd_addr]; end
      if (win == 1) mem_m[pwr_addr] = pwr_wdata;
      if (win == 2) begin
        if (ic_we) mem_m[ic_addr] = ic_wdata;
        else begin rsp_kind = 2; rsp_data = mem_m[ic_addr]; end
      end
      for (int i = 0; i < 3; i++) begin
        got[i] = g[i];
        if (!v[i] || g[i]) wcnt[i] = 0;
        else if (wcnt[i] < LIM) wcnt[i]++;
      end
      dem_m = cfg_wr_demote;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // traffic: a class refreshes its request only when idle or just granted
  task automatic traffic(input int n, input int p0, input int p1, input int p2, input int tog);
    for (int k = 0; k < n; k++) begin
      step();
      if (tog > 0 && (k % tog) == 0) cfg_wr_demote = ~cfg_wr_demote;
      if (!prd_valid || got[0]) begin
        prd_valid = ($urandom % 100) < p0; prd_addr = AW'($urandom % 16);
      end
      if (!pwr_valid || got[1]) begin
        pwr_valid = ($urandom % 100) < p1; pwr_addr = AW'($urandom % 16); pwr_wdata = $urandom;
      end
      if (!ic_valid || got[2]) begin
        ic_valid = ($urandom % 100) < p2; ic_addr = AW'($urandom % 16);
        ic_we = $urandom % 2; ic_wdata = $urandom;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem_b[i] = DW'(i * 32'h01010101); mem_m[i] = mem_b[i]; end
    mem_rdata = '0;
    rst_n = 0; cfg_wr_demote = 0;
    prd_valid = 0; prd_addr = '0; pwr_valid = 0; pwr_addr = '0; pwr_wdata = '0;
    ic_valid = 0; ic_we = 0; ic_addr = '0; ic_wdata = '0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    check(!prd_rvalid && !ic_rvalid && !mem_en && !prd_ready && !pwr_ready && !ic_ready,
          "R10", "reset outputs", {prd_rvalid, ic_rvalid, mem_en}, 0);
    step(); rst_n = 1; mon_on = 1;
    // R2 directed: write then read same word
    step(); pwr_valid = 1; pwr_addr = 8'd5; pwr_wdata = 32'hCAFE_0005;
    step(); pwr_valid = 0; prd_valid = 1; prd_addr = 8'd5;
    step(); prd_valid = 0; ic_valid = 1; ic_we = 0; ic_addr = 8'd5;
    step(); ic_valid = 0;
    // R2: all three at once with demote clear
    step(); prd_valid = 1; pwr_valid = 1; ic_valid = 1; ic_we = 1; ic_addr = 8'd9; ic_wdata = 32'h99;
    step(); prd_valid = 0;
    step(); pwr_valid = 0;
    step(); ic_valid = 0;
    // R4: demote set, pwr and ic together
    cfg_wr_demote = 1;
    step(); pwr_valid = 1; ic_valid = 1;
    step(); ic_valid = 0;
    step(); pwr_valid = 0;
    cfg_wr_demote = 0;
    step();
    // R7: ic waits, drops, re-asserts under a steady read stream
    r7_phase = 1;
    prd_valid = 1; ic_valid = 1; ic_we = 0; ic_addr = 8'd3;
    repeat (3) step();
    ic_valid = 0; step();
    ic_valid = 1;
    repeat (LIM + 2) step();
    r7_phase = 0;
    prd_valid = 0; ic_valid = 0; step();
    // R6: saturated traffic forces starvation, both orders and toggling (R5)
    traffic(300, 100, 100, 100, 0);
    cfg_wr_demote = 1;
    traffic(300, 100, 100, 100, 0);
    traffic(400, 60, 60, 60, 7);
    cfg_wr_demote = 0;
    traffic(400, 40, 50, 50, 3);
    prd_valid = 0; pwr_valid = 0; ic_valid = 0;
    repeat (3) step();
    finish_run();
  end
endmodule